// File: doc/BRIEF.md
# Streaming Determinant Pipeline

This block evaluates a fixed polynomial expression of six signed operands, `a` through `f`, as a stream. A new operand set may be offered on every clock, marked by `in_valid`. Each set yields one full-precision signed result on `out_det` exactly five clocks later, marked by `out_valid`. The block has no handshake and never stalls.

The expression is split into five register stages:
- first cycle: `p = a*b`, `q = e*f` and `s = c+d`;
- second cycle: `u = s*b` and `w = s + (q >>> 2)`;
- third cycle: `x = p*w` and `y = a + q`;
- fourth cycle: `z = y*u`;
- fifth cycle: `x - z` is registered as the output.

Every operation has its own arithmetic unit, so one result can leave per clock. The stage registers carry forward the operands and partial results that later stages still need. A valid bit travels alongside the data. The data registers are not reset and may hold stale values whenever `out_valid` is low.

The result is `out_det = a*b*(c + d + floor(e*f/4)) - (a + e*f)*(c + d)*b`, computed without loss of precision.

Top module: `det_pipe`

## Requirements
- R1: When `out_valid` is high, `out_det` equals `a*b*(c+d+floor(e*f/4)) - (a+e*f)*(c+d)*b` for the operand set sampled five clocks earlier, with all operands signed two's complement.
- R2: The quarter of `e*f` is an arithmetic right shift by two, which rounds toward minus infinity. For example, with `e*f = -1`, `a=b=1` and `c=d=0`, the result is -1.
- R3: Intermediates and the result keep full signed precision. Operands at the most negative and most positive values produce the exact result, with no wrap.
- R4: A set sampled at clock edge n appears on the outputs after edge n+4, and not before.
- R5: Sets offered on consecutive clocks give distinct, correct results on consecutive clocks, which is an initiation interval of one.
- R6: `out_valid` equals `in_valid` delayed by five clocks, including gaps in the input stream.
- R7: Synchronous reset clears the valid chain. While reset is high, and for the first four edges after it is released, `out_valid` stays low even if `in_valid` was held high during reset.
- R8: A set offered with `in_valid` low never raises `out_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high, clears the valid chain only |
| in_valid | input | 1 | Marks a new operand set |
| in_a | input | W | Signed operand a |
| in_b | input | W | Signed operand b |
| in_c | input | W | Signed operand c |
| in_d | input | W | Signed operand d |
| in_e | input | W | Signed operand e |
| in_f | input | W | Signed operand f |
| out_valid | output | 1 | Marks a valid result |
| out_det | output | 4*W+3 | Signed result |

## Verification
A set driven before edge n is due on the outputs after edge n+4. The bench drives operands on falling edges. At falling edge i it compares both outputs against the set it drove at falling edge i-5, so each result is checked at exactly its due cycle: one cycle early would show a different set or an invalid flag. At every falling edge `out_valid` is compared against the delayed `in_valid`. During the first five cycles after reset it must be low.

// File: rtl/det_pipe_pkg.sv
package det_pipe_pkg;
  // number of register stages from operand sampling to result
  localparam int DET_LAT = 5;
  // shift that implements the divide by four
  localparam int QSHIFT = 2;

  function automatic int sum_w(input int aw, input int bw);
    return ((aw > bw) ? aw : bw) + 1;
  endfunction

  function automatic int prod_w(input int aw, input int bw);
    return aw + bw;
  endfunction
endpackage

// File: rtl/det_mul.sv
module det_mul
  import det_pipe_pkg::*;
#(
  parameter int AW = 16,
  parameter int BW = 16,
  parameter int OW = prod_w(AW, BW)
) (
  input  logic signed [AW-1:0] op_a,
  input  logic signed [BW-1:0] op_b,
  output logic signed [OW-1:0] prod
);
  function automatic logic signed [OW-1:0] smul(input logic signed [AW-1:0] x,
                                                input logic signed [BW-1:0] y);
    logic signed [OW-1:0] xe;
    logic signed [OW-1:0] ye;
    xe = x;
    ye = y;
    return xe * ye;
  endfunction

  assign prod = smul(op_a, op_b);

  logic ops_nonzero;
  logic sign_expect;
  assign ops_nonzero = (op_a != '0) && (op_b != '0);
  assign sign_expect = op_a[AW-1] ^ op_b[BW-1];

  always_comb begin
    if (ops_nonzero) begin
      // R3
      mul_sign_chk: assert (prod[OW-1] == sign_expect)
        else $error("product sign lost precision");
    end
  end
endmodule

// File: rtl/det_addsub.sv
module det_addsub
  import det_pipe_pkg::*;
#(
  parameter int AW  = 16,
  parameter int BW  = 16,
  parameter bit SUB = 1'b0,
  parameter int OW  = sum_w(AW, BW)
) (
  input  logic signed [AW-1:0] op_a,
  input  logic signed [BW-1:0] op_b,
  output logic signed [OW-1:0] res
);
  function automatic logic signed [OW-1:0] combine(input logic signed [AW-1:0] x,
                                                   input logic signed [BW-1:0] y);
    logic signed [OW-1:0] xe;
    logic signed [OW-1:0] ye;
    xe = x;
    ye = y;
    if (SUB) return xe - ye;
    return xe + ye;
  endfunction

  assign res = combine(op_a, op_b);
endmodule

// File: rtl/det_valid_chain.sv
module det_valid_chain #(
  parameter int DEPTH = 5
) (
  input  logic clk,
  input  logic rst,
  input  logic vin,
  output logic vout
);
  logic [DEPTH-1:0] vbits;

  for (genvar g = 0; g < DEPTH; g++) begin : g_stage
    if (g == 0) begin : g_head
      always_ff @(posedge clk) begin
        if (rst) vbits[g] <= 1'b0;
        else     vbits[g] <= vin;
      end
    end else begin : g_body
      always_ff @(posedge clk) begin
        if (rst) vbits[g] <= 1'b0;
        else     vbits[g] <= vbits[g-1];
      end
    end
  end

  assign vout = vbits[DEPTH-1];
endmodule

// File: rtl/det_pipe.sv
module det_pipe
  import det_pipe_pkg::*;
#(
  parameter  int W  = 16,
  localparam int DW = 4 * W + 3
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  input  logic signed [W-1:0]  in_a,
  input  logic signed [W-1:0]  in_b,
  input  logic signed [W-1:0]  in_c,
  input  logic signed [W-1:0]  in_d,
  input  logic signed [W-1:0]  in_e,
  input  logic signed [W-1:0]  in_f,
  output logic                 out_valid,
  output logic signed [DW-1:0] out_det
);
  // widths of every intermediate
  localparam int PW = prod_w(W, W);      // p, q
  localparam int SW = sum_w(W, W);       // s
  localparam int QW = PW - QSHIFT;       // q / 4
  localparam int WW = sum_w(SW, QW);     // w
  localparam int UW = prod_w(SW, W);     // u
  localparam int YW = sum_w(W, PW);      // y
  localparam int XW = prod_w(PW, WW);    // x
  localparam int ZW = prod_w(YW, UW);    // z
  localparam int RW = sum_w(XW, ZW);     // result

  // ---------------- stage 1 ----------------
  logic signed [PW-1:0] p_c, q_c;
  logic signed [SW-1:0] s_c;
  logic signed [PW-1:0] p_r1, q_r1;
  logic signed [SW-1:0] s_r1;
  logic signed [W-1:0]  a_r1, b_r1;

  det_mul #(.AW(W), .BW(W), .OW(PW)) u_mul_p (.op_a(in_a), .op_b(in_b), .prod(p_c));
  det_mul #(.AW(W), .BW(W), .OW(PW)) u_mul_q (.op_a(in_e), .op_b(in_f), .prod(q_c));
  det_addsub #(.AW(W), .BW(W), .SUB(1'b0), .OW(SW)) u_add_s (.op_a(in_c), .op_b(in_d), .res(s_c));

  always_ff @(posedge clk) begin
    p_r1 <= p_c;
    q_r1 <= q_c;
    s_r1 <= s_c;
    a_r1 <= in_a;
    b_r1 <= in_b;
  end

  // ---------------- stage 2 ----------------
  logic signed [QW-1:0] q_quarter;
  logic signed [UW-1:0] u_c;
  logic signed [WW-1:0] w_c;
  logic signed [UW-1:0] u_r2;
  logic signed [WW-1:0] w_r2;
  logic signed [PW-1:0] p_r2, q_r2;
  logic signed [W-1:0]  a_r2;

  // divide by four: drop the two low bits, keep the sign (floor)
  assign q_quarter = q_r1[PW-1:QSHIFT];

  det_mul #(.AW(SW), .BW(W), .OW(UW)) u_mul_u (.op_a(s_r1), .op_b(b_r1), .prod(u_c));
  det_addsub #(.AW(SW), .BW(QW), .SUB(1'b0), .OW(WW)) u_add_w (.op_a(s_r1), .op_b(q_quarter), .res(w_c));

  always_ff @(posedge clk) begin
    u_r2 <= u_c;
    w_r2 <= w_c;
    p_r2 <= p_r1;
    q_r2 <= q_r1;
    a_r2 <= a_r1;
  end

  // ---------------- stage 3 ----------------
  logic signed [XW-1:0] x_c;
  logic signed [YW-1:0] y_c;
  logic signed [XW-1:0] x_r3;
  logic signed [YW-1:0] y_r3;
  logic signed [UW-1:0] u_r3;

  det_mul #(.AW(PW), .BW(WW), .OW(XW)) u_mul_x (.op_a(p_r2), .op_b(w_r2), .prod(x_c));
  det_addsub #(.AW(W), .BW(PW), .SUB(1'b0), .OW(YW)) u_add_y (.op_a(a_r2), .op_b(q_r2), .res(y_c));

  always_ff @(posedge clk) begin
    x_r3 <= x_c;
    y_r3 <= y_c;
    u_r3 <= u_r2;
  end

  // ---------------- stage 4 ----------------
  logic signed [ZW-1:0] z_c;
  logic signed [ZW-1:0] z_r4;
  logic signed [XW-1:0] x_r4;

  det_mul #(.AW(YW), .BW(UW), .OW(ZW)) u_mul_z (.op_a(y_r3), .op_b(u_r3), .prod(z_c));

  always_ff @(posedge clk) begin
    z_r4 <= z_c;
    x_r4 <= x_r3;
  end

  // ---------------- stage 5 ----------------
  logic signed [RW-1:0] r_c;
  logic signed [RW-1:0] r_r5;

  det_addsub #(.AW(XW), .BW(ZW), .SUB(1'b1), .OW(RW)) u_sub_r (.op_a(x_r4), .op_b(z_r4), .res(r_c));

  always_ff @(posedge clk) begin
    r_r5 <= r_c;
  end

  assign out_det = DW'(r_r5);

  // ---------------- valid chain ----------------
  det_valid_chain #(.DEPTH(DET_LAT)) u_vchain (
    .clk (clk),
    .rst (rst),
    .vin (in_valid),
    .vout(out_valid)
  );

  // ---------------- checks ----------------
  // edges seen since reset was released, saturating at the latency
  logic [3:0] since_rst;
  always_ff @(posedge clk) begin
    if (rst)                       since_rst <= '0;
    else if (since_rst < DET_LAT)  since_rst <= since_rst + 4'd1;
  end

  function automatic logic signed [DW-1:0] det_ref(
    input logic signed [W-1:0] a, input logic signed [W-1:0] b,
    input logic signed [W-1:0] c, input logic signed [W-1:0] d,
    input logic signed [W-1:0] e, input logic signed [W-1:0] f);
    logic signed [DW-1:0] ab, ef, cd;
    ab = DW'(a) * DW'(b);
    ef = DW'(e) * DW'(f);
    cd = DW'(c) + DW'(d);
    return ab * (cd + (ef >>> QSHIFT)) - (DW'(a) + ef) * cd * DW'(b);
  endfunction

  // R7
  warmup_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (since_rst < DET_LAT) |-> !out_valid);

  // R6
  valid_delay_chk: assert property (@(posedge clk) disable iff (rst)
    (since_rst == DET_LAT) |-> (out_valid == $past(in_valid, 5)));

  // R1
  det_value_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_det == det_ref($past(in_a, 5), $past(in_b, 5), $past(in_c, 5),
                                      $past(in_d, 5), $past(in_e, 5), $past(in_f, 5))));

  // R2
  quarter_floor_chk: assert property (@(posedge clk) disable iff (rst)
    (since_rst >= 4'd2) |-> (w_r2 - WW'($past(s_c, 2)) == WW'($signed($past(q_c, 2)) >>> QSHIFT)));
endmodule

// File: tb/sim_det_pipe.sv
`timescale 1ns/1ps
module sim_det_pipe;
  localparam int W  = 16;
  localparam int DW = 4 * W + 3;
  localparam int N  = 400;
  localparam int EW = 80;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic signed [W-1:0] in_a = '0, in_b = '0, in_c = '0, in_d = '0, in_e = '0, in_f = '0;
  logic out_valid;
  logic signed [DW-1:0] out_det;

  always #2 clk = ~clk;

  det_pipe #(.W(W)) u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid),
    .in_a(in_a), .in_b(in_b), .in_c(in_c), .in_d(in_d), .in_e(in_e), .in_f(in_f),
    .out_valid(out_valid), .out_det(out_det)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  logic signed [W-1:0] sa [N], sb [N], sc [N], sd [N], se [N], sf [N];
  logic sv [N];

  // expanded form, distinct from the staged evaluation
  function automatic logic signed [EW-1:0] expect_det(
    input logic signed [W-1:0] a, input logic signed [W-1:0] b,
    input logic signed [W-1:0] c, input logic signed [W-1:0] d,
    input logic signed [W-1:0] e, input logic signed [W-1:0] f);
    logic signed [EW-1:0] ae, be, ce, de, prod_ef, quarter, ab;
    ae = a; be = b; ce = c; de = d;
    prod_ef = EW'(e) * EW'(f);
    quarter = prod_ef >>> 2;
    ab = ae * be;
    return ab * ce + ab * de + ab * quarter
         - ae * ce * be - ae * de * be - prod_ef * ce * be - prod_ef * de * be;
  endfunction

  task automatic chk_bit(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s out_valid actual %0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic chk_det(input string req, input logic signed [EW-1:0] act,
                         input logic signed [EW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s out_det actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #200000;
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int k = 0; k < N; k++) begin
      sa[k] = W'($urandom); sb[k] = W'($urandom); sc[k] = W'($urandom);
      sd[k] = W'($urandom); se[k] = W'($urandom); sf[k] = W'($urandom);
      sv[k] = ($urandom % 4) != 0;
    end
    for (int k = 6; k < 20; k++) sv[k] = 1'b1;  // back-to-back burst, R5
    // R2: e*f = -1 must floor to -1
    sa[0] = 1; sb[0] = 1; sc[0] = 0; sd[0] = 0; se[0] = -1; sf[0] = 1; sv[0] = 1;
    // R3: most negative extremes
    sa[1] = -32768; sb[1] = -32768; sc[1] = -32768; sd[1] = -32768; se[1] = -32768; sf[1] = -32768; sv[1] = 1;
    // R3: most positive extremes
    sa[2] = 32767; sb[2] = 32767; sc[2] = 32767; sd[2] = 32767; se[2] = 32767; sf[2] = 32767; sv[2] = 1;
    // R3: mixed signs at the limits
    sa[3] = -32768; sb[3] = 32767; sc[3] = 32767; sd[3] = 32767; se[3] = -32768; sf[3] = 32767; sv[3] = 1;
    sa[4] = 0; sb[4] = 0; sc[4] = 0; sd[4] = 0; se[4] = 0; sf[4] = 0; sv[4] = 1;
    // R8: data with in_valid low
    sa[5] = 1234; sb[5] = -77; sc[5] = 5; sd[5] = 9; se[5] = 3; sf[5] = -3; sv[5] = 0;

    // reset with in_valid held high, R7
    in_valid = 1'b1;
    repeat (4) begin
      @(negedge clk);
      chk_bit("R7", out_valid, 1'b0);
    end

    for (int i = 0; i < N + 5; i++) begin
      @(negedge clk);
      if (i == 0) rst = 1'b0;
      if (i < 5) begin
        chk_bit("R7", out_valid, 1'b0);
      end else begin
        chk_bit(sv[i-5] ? "R6" : "R8", out_valid, sv[i-5]);
        if (sv[i-5] && out_valid) begin
          chk_det((i - 5 == 0) ? "R2" : (i - 5 <= 3) ? "R3" : (i - 5 < 20) ? "R5" : "R1",
                  EW'(out_det),
                  expect_det(sa[i-5], sb[i-5], sc[i-5], sd[i-5], se[i-5], sf[i-5]));
        end
        // R4: the set after this one must not have surfaced yet
        if (i == 5) chk_det("R4", EW'(out_det),
                            expect_det(sa[0], sb[0], sc[0], sd[0], se[0], sf[0]));
      end
      if (i < N) begin
        in_valid = sv[i];
        in_a = sa[i]; in_b = sb[i]; in_c = sc[i]; in_d = sd[i]; in_e = se[i]; in_f = sf[i];
      end else begin
        in_valid = 1'b0;
      end
    end
    finish_run();
  end
endmodule